// File: doc/BRIEF.md
# Shift-Rotate Unit with Flags

This block performs one 64-bit shift or rotate on a single operand per request. It produces the new carry and overflow flags, and for shift operations the sign, zero and parity flags. A 3-bit select chooses among seven operations:

- rotate left and rotate right;
- rotate left and rotate right through the carry flag, where the operand and the incoming carry form a 65-bit ring;
- logical shift left, logical shift right and arithmetic shift right.

Only the low six bits of the count are used. A masked count of zero leaves the operand unchanged and raises no flag write enable.

The block has a two-state controller. In `ST_IDLE`, `req_ready` is high. A request with `req_valid` high is captured at the clock edge, and the controller moves to `ST_RESP`. In `ST_RESP`, the registered operation drives the response outputs, `rsp_valid` is high for that one cycle, and the controller returns to `ST_IDLE` unconditionally at the next edge. The host writes the carry and overflow pair when `rsp_cfof_we` is high. It writes sign, zero and parity when `rsp_szp_we` is high. Rotates never raise `rsp_szp_we`.

Top module: `srf_unit`

## Requirements
- R1: The controller starts in `ST_IDLE` with `req_ready`=1. A request accepted in `ST_IDLE` gives `rsp_valid`=1 and `req_ready`=0 in the next cycle only, and the controller is back in `ST_IDLE` the cycle after.
- R2: Only `req_count[5:0]` is used. The bits above it have no effect on any output.
- R3: When the masked count is zero, `rsp_result` equals the operand and both `rsp_cfof_we` and `rsp_szp_we` are 0.
- R4: Select 0 is rotate left. Carry is result bit 0, and overflow is result bit 0 XOR result bit 63.
- R5: Select 1 is rotate right. Carry is result bit 63, and overflow is result bit 62 XOR result bit 63.
- R6: Select 2 rotates the 65-bit ring {carry, operand} left by the count. The result is the low 64 ring bits, carry is ring bit 64 (operand bit 64−count), and overflow is carry XOR result bit 63.
- R7: Select 3 rotates the same ring right by the count. Carry is operand bit count−1, and overflow is result bit 62 XOR result bit 63.
- R8: Select 4 is a logical shift left, and select 6 behaves exactly like it. Carry is operand bit 64−count, and overflow is carry XOR result bit 63.
- R9: Select 5 is a logical shift right. Carry is operand bit count−1, and overflow is result bit 62 XOR result bit 63, which is 0 for counts of 2 or more.
- R10: Select 7 is an arithmetic shift right. It fills with operand bit 63, takes carry from operand bit count−1, and always gives overflow 0.
- R11: For shifts with a nonzero count, `rsp_szp_we`=1, sign is result bit 63, zero is 1 when the result is 0, and parity is 1 when result bits 7:0 hold an even number of ones. Rotates give `rsp_szp_we`=0.
- R12: For any nonzero masked count, `rsp_cfof_we`=1 on the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request (`ST_IDLE`) |
| req_op | input | 3 | Operation select (encoding in R4–R10) |
| req_count | input | 8 | Shift or rotate count; low 6 bits used |
| req_operand | input | 64 | Operand |
| req_carry | input | 1 | Incoming carry flag |
| rsp_valid | output | 1 | Response cycle (`ST_RESP`) |
| rsp_result | output | 64 | Result |
| rsp_carry | output | 1 | New carry flag |
| rsp_overflow | output | 1 | New overflow flag |
| rsp_sign | output | 1 | New sign flag |
| rsp_zero | output | 1 | New zero flag |
| rsp_parity | output | 1 | New parity flag (even parity of low byte) |
| rsp_cfof_we | output | 1 | Write enable for carry and overflow |
| rsp_szp_we | output | 1 | Write enable for sign, zero and parity |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing after each accepted request;
- the silent write enables for a zero count;
- the absence of sign/zero/parity enables on rotates;
- the carry-to-result-bit relations of the plain rotates;
- overflow being clear for arithmetic right shifts and for logical right shifts of two or more.

Only the bench's scenarios can show the exact result bits, the placement of the carry inside the 65-bit ring, and the bit of the operand each carry is taken from. The bench covers these through a directed vector table and a sweep of every count from 0 to 63 for every select, with several operand patterns. The same scenarios also show that the upper count bits are ignored.

// File: rtl/srf_pkg.sv
package srf_pkg;

    typedef enum logic [2:0] {
        OP_ROL     = 3'd0,
        OP_ROR     = 3'd1,
        OP_RCL     = 3'd2,
        OP_RCR     = 3'd3,
        OP_SHL     = 3'd4,
        OP_SHR     = 3'd5,
        OP_SHL_ALT = 3'd6,
        OP_SAR     = 3'd7
    } srf_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } srf_state_e;

endpackage

// File: rtl/srf_datapath.sv
// Result, carry and overflow for every select; W must be a power of two.
module srf_datapath
    import srf_pkg::*;
#(
    parameter int W  = 64,
    parameter int CW = $clog2(W)
) (
    input  srf_op_e         op,
    input  logic [CW-1:0]   cnt,
    input  logic [W-1:0]    opnd,
    input  logic            cin,
    output logic [W-1:0]    res,
    output logic            cf,
    output logic            of,
    output logic            is_rotate
);
    localparam int RW = W + 1;

    logic [W-1:0]  rol_res, ror_res, shl_res, shr_res, sar_res;
    logic [RW-1:0] ring, rcl_ring, rcr_ring;
    logic [CW-1:0] right_idx, left_idx;
    logic          right_cf, left_cf;

    // Shifts by W (count 0) produce zero, so the OR keeps the operand.
    assign rol_res  = (opnd << cnt) | (opnd >> (W - int'(cnt)));
    assign ror_res  = (opnd >> cnt) | (opnd << (W - int'(cnt)));
    assign ring     = {cin, opnd};
    assign rcl_ring = (ring << cnt) | (ring >> (RW - int'(cnt)));
    assign rcr_ring = (ring >> cnt) | (ring << (RW - int'(cnt)));
    assign shl_res  = opnd << cnt;
    assign shr_res  = opnd >> cnt;
    assign sar_res  = W'($signed(opnd) >>> cnt);

    // Last bit shifted out: count-1 for right moves, W-count for left moves.
    assign right_idx = cnt - CW'(1);
    assign left_idx  = '0 - cnt;
    assign right_cf  = opnd[right_idx];
    assign left_cf   = opnd[left_idx];

    always_comb begin
        res       = shl_res;
        cf        = left_cf;
        of        = 1'b0;
        is_rotate = 1'b0;
        unique case (op)
            OP_ROL: begin
                res       = rol_res;
                cf        = rol_res[0];
                of        = rol_res[0] ^ rol_res[W-1];
                is_rotate = 1'b1;
            end
            OP_ROR: begin
                res       = ror_res;
                cf        = ror_res[W-1];
                of        = ror_res[W-2] ^ ror_res[W-1];
                is_rotate = 1'b1;
            end
            OP_RCL: begin
                res       = rcl_ring[W-1:0];
                cf        = rcl_ring[W];
                of        = rcl_ring[W] ^ rcl_ring[W-1];
                is_rotate = 1'b1;
            end
            OP_RCR: begin
                res       = rcr_ring[W-1:0];
                cf        = rcr_ring[W];
                of        = rcr_ring[W-2] ^ rcr_ring[W-1];
                is_rotate = 1'b1;
            end
            OP_SHL, OP_SHL_ALT: begin
                res = shl_res;
                cf  = left_cf;
                of  = left_cf ^ shl_res[W-1];
            end
            OP_SHR: begin
                res = shr_res;
                cf  = right_cf;
                of  = shr_res[W-2] ^ shr_res[W-1];
            end
            OP_SAR: begin
                res = sar_res;
                cf  = right_cf;
                of  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/srf_flaggen.sv
module srf_flaggen #(
    parameter int W  = 64,
    parameter int PB = 8
) (
    input  logic [W-1:0] res,
    output logic         sign,
    output logic         zero,
    output logic         parity
);
    assign sign   = res[W-1];
    assign zero   = ~|res;
    assign parity = ~^res[PB-1:0];
endmodule

// File: rtl/srf_unit.sv
module srf_unit
    import srf_pkg::*;
#(
    parameter int WIDTH    = 64,
    parameter int CNT_IN_W = 8,
    parameter int PAR_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [2:0]          req_op,
    input  logic [CNT_IN_W-1:0] req_count,
    input  logic [WIDTH-1:0]    req_operand,
    input  logic                req_carry,
    output logic                rsp_valid,
    output logic [WIDTH-1:0]    rsp_result,
    output logic                rsp_carry,
    output logic                rsp_overflow,
    output logic                rsp_sign,
    output logic                rsp_zero,
    output logic                rsp_parity,
    output logic                rsp_cfof_we,
    output logic                rsp_szp_we
);
    localparam int CW = $clog2(WIDTH);

    srf_state_e      state, state_nx;
    srf_op_e         op_q;
    logic [CW-1:0]   cnt_q;
    logic [WIDTH-1:0] opnd_q;
    logic            cin_q;
    logic            accept;
    logic            unused_count_hi;

    logic [WIDTH-1:0] dp_res;
    logic            dp_cf, dp_of, dp_rot;
    logic            fl_sign, fl_zero, fl_par;
    logic            cnt_nz;

    assign accept          = req_valid && (state == ST_IDLE);
    assign unused_count_hi = ^req_count[CNT_IN_W-1:CW];

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= OP_ROL;
            cnt_q  <= '0;
            opnd_q <= '0;
            cin_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                op_q   <= srf_op_e'(req_op);
                cnt_q  <= req_count[CW-1:0];
                opnd_q <= req_operand;
                cin_q  <= req_carry;
            end
        end
    end

    srf_datapath #(.W(WIDTH), .CW(CW)) i_dp (
        .op        (op_q),
        .cnt       (cnt_q),
        .opnd      (opnd_q),
        .cin       (cin_q),
        .res       (dp_res),
        .cf        (dp_cf),
        .of        (dp_of),
        .is_rotate (dp_rot)
    );

    srf_flaggen #(.W(WIDTH), .PB(PAR_BITS)) i_fl (
        .res    (dp_res),
        .sign   (fl_sign),
        .zero   (fl_zero),
        .parity (fl_par)
    );

    assign cnt_nz = (cnt_q != '0);

    always_comb begin
        req_ready    = (state == ST_IDLE);
        rsp_valid    = (state == ST_RESP);
        rsp_result   = cnt_nz ? dp_res : opnd_q;
        rsp_carry    = cnt_nz ? dp_cf : cin_q;
        rsp_overflow = cnt_nz & dp_of;
        rsp_sign     = fl_sign;
        rsp_zero     = fl_zero;
        rsp_parity   = fl_par;
        rsp_cfof_we  = rsp_valid & cnt_nz;
        rsp_szp_we   = rsp_valid & cnt_nz & ~dp_rot;
    end

    // R1: response comes exactly one cycle after acceptance, for one cycle.
    a_r1_resp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid && !req_ready));
    a_r1_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));
    // R3: zero count writes no flag and passes the operand.
    a_r3_zero_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cnt_q == '0) |-> (!rsp_cfof_we && !rsp_szp_we && rsp_result == opnd_q));
    // R4: rotate-left carry mirrors result bit 0.
    a_r4_rol_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_cfof_we && op_q == OP_ROL) |-> (rsp_carry == rsp_result[0]));
    // R5: rotate-right carry mirrors result bit 63.
    a_r5_ror_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_cfof_we && op_q == OP_ROR) |-> (rsp_carry == rsp_result[WIDTH-1]));
    // R9: logical right shift by two or more never overflows.
    a_r9_shr_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && op_q == OP_SHR && cnt_q > CW'(1)) |-> !rsp_overflow);
    // R10: arithmetic right shift never overflows.
    a_r10_sar_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && op_q == OP_SAR) |-> !rsp_overflow);
    // R11: rotates leave sign, zero and parity alone.
    a_r11_rotate_keeps_szp: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && op_q inside {OP_ROL, OP_ROR, OP_RCL, OP_RCR}) |-> !rsp_szp_we);
endmodule

// File: tb/test_srf_unit.sv
module test_srf_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = 3'd0;
    logic [7:0]  req_count = 8'd0;
    logic [63:0] req_operand = 64'd0;
    logic        req_carry = 1'b0;
    logic        rsp_valid;
    logic [63:0] rsp_result;
    logic        rsp_carry, rsp_overflow, rsp_sign, rsp_zero, rsp_parity;
    logic        rsp_cfof_we, rsp_szp_we;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    srf_unit i_srf_unit (
        .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_count,
        .req_operand, .req_carry, .rsp_valid, .rsp_result, .rsp_carry,
        .rsp_overflow, .rsp_sign, .rsp_zero, .rsp_parity,
        .rsp_cfof_we, .rsp_szp_we
    );

    // {op, count, operand, carry_in, result, cf, of, cfof_we, szp_we}
    localparam int NV = 12;
    localparam logic [143:0] VEC [NV] = '{
        {3'd0, 8'd4,   64'h8000_0000_0000_0001, 1'b0, 64'h0000_0000_0000_0018, 1'b0, 1'b0, 1'b1, 1'b0},
        {3'd1, 8'd1,   64'h0000_0000_0000_0001, 1'b0, 64'h8000_0000_0000_0000, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd2, 8'd1,   64'h8000_0000_0000_0000, 1'b1, 64'h0000_0000_0000_0001, 1'b1, 1'b1, 1'b1, 1'b0},
        {3'd3, 8'd1,   64'h0000_0000_0000_0000, 1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b1, 1'b0},
        {3'd4, 8'd1,   64'h4000_0000_0000_0000, 1'b0, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b1, 1'b1},
        {3'd5, 8'd4,   64'h0000_0000_0000_00F0, 1'b0, 64'h0000_0000_0000_000F, 1'b0, 1'b0, 1'b1, 1'b1},
        {3'd7, 8'd63,  64'h8000_0000_0000_0000, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b1},
        {3'd5, 8'd1,   64'h8000_0000_0000_0001, 1'b0, 64'h4000_0000_0000_0000, 1'b1, 1'b1, 1'b1, 1'b1},
        {3'd4, 8'h41,  64'h0000_0000_0000_0001, 1'b0, 64'h0000_0000_0000_0002, 1'b0, 1'b0, 1'b1, 1'b1},
        {3'd0, 8'h40,  64'h0000_0000_0000_1234, 1'b1, 64'h0000_0000_0000_1234, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'd6, 8'd2,   64'h0000_0000_0000_0003, 1'b0, 64'h0000_0000_0000_000C, 1'b0, 1'b0, 1'b1, 1'b1},
        {3'd4, 8'd1,   64'h8000_0000_0000_0000, 1'b0, 64'h0000_0000_0000_0000, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    function automatic string req_of(input logic [2:0] op, input logic [5:0] c);
        if (c == 6'd0) return "R3";
        case (op)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4, 3'd6: return "R8";
            3'd5: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Step-by-step reference, one bit position per iteration.
    task automatic ref_model(input logic [2:0] op, input logic [7:0] cnt_in,
                             input logic [63:0] a, input logic cin,
                             output logic [63:0] r, output logic cf, output logic of,
                             output logic cwe, output logic swe);
        logic [5:0]  c;
        logic [64:0] ring;
        c    = cnt_in[5:0];
        r    = a;
        cf   = cin;
        of   = 1'b0;
        ring = {cin, a};
        cwe  = (c != 0);
        swe  = (c != 0) && (op >= 3'd4);
        for (int k = 0; k < int'(c); k++) begin
            case (op)
                3'd0: r = {r[62:0], r[63]};
                3'd1: r = {r[0], r[63:1]};
                3'd2: ring = {ring[63:0], ring[64]};
                3'd3: ring = {ring[0], ring[64:1]};
                3'd4, 3'd6: begin cf = r[63]; r = {r[62:0], 1'b0}; end
                3'd5: begin cf = r[0]; r = {1'b0, r[63:1]}; end
                default: begin cf = r[0]; r = {r[63], r[63:1]}; end
            endcase
        end
        if (c != 0) begin
            case (op)
                3'd0: begin cf = r[0]; of = r[0] ^ r[63]; end
                3'd1: begin cf = r[63]; of = r[62] ^ r[63]; end
                3'd2: begin r = ring[63:0]; cf = ring[64]; of = cf ^ r[63]; end
                3'd3: begin r = ring[63:0]; cf = ring[64]; of = r[62] ^ r[63]; end
                3'd4, 3'd6: of = cf ^ r[63];
                3'd5: of = r[62] ^ r[63];
                default: of = 1'b0;
            endcase
        end
    endtask

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Issue one request; sample the response cycle half a period after the edge.
    task automatic run(input logic [2:0] op, input logic [7:0] cnt,
                       input logic [63:0] a, input logic cin,
                       input logic [63:0] er, input logic ecf, input logic eof,
                       input logic ecwe, input logic eswe);
        string tag;
        int    ones;
        tag = req_of(op, cnt[5:0]);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_count = cnt; req_operand = a; req_carry = cin;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1", "rsp_valid", 64'(rsp_valid), 64'd1);
        check(tag, "result", rsp_result, er);
        check(ecwe ? "R12" : "R3", "cfof_we", 64'(rsp_cfof_we), 64'(ecwe));
        check(eswe ? "R11" : (ecwe ? "R11" : "R3"), "szp_we", 64'(rsp_szp_we), 64'(eswe));
        if (ecwe) check(tag, "carry/overflow", {62'd0, rsp_carry, rsp_overflow}, {62'd0, ecf, eof});
        if (eswe) begin
            ones = 0;
            for (int b = 0; b < 8; b++) ones += int'(er[b]);
            check("R11", "sign/zero/parity", {61'd0, rsp_sign, rsp_zero, rsp_parity},
                  {61'd0, er[63], (er == 64'd0), (ones % 2 == 0)});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "reset ready", 64'(req_ready), 64'd1);
        check("R1", "reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1", "reset we", {62'd0, rsp_cfof_we, rsp_szp_we}, 64'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [143:0] e;
            e = VEC[v];
            run(e[143:141], e[140:133], e[132:69], e[68], e[67:4], e[3], e[2], e[1], e[0]);
        end

        // R1: the cycle after the response, back to idle with no response
        @(negedge clk);
        check("R1", "idle after resp", {62'd0, rsp_valid, req_ready}, 64'd1);

        // R2: upper count bits ignored (0xC3 acts as 3)
        begin
            logic [63:0] r; logic cf, of, cwe, swe;
            ref_model(3'd4, 8'd3, 64'h0123_4567_89AB_CDEF, 1'b0, r, cf, of, cwe, swe);
            run(3'd4, 8'hC3, 64'h0123_4567_89AB_CDEF, 1'b0, r, cf, of, cwe, swe);
            ref_model(3'd3, 8'd5, 64'hF00D_0000_BEEF_0011, 1'b1, r, cf, of, cwe, swe);
            run(3'd3, 8'h85, 64'hF00D_0000_BEEF_0011, 1'b1, r, cf, of, cwe, swe);
        end

        // Sweep every select and count with several operand patterns (R4..R11)
        for (int op = 0; op < 8; op++) begin
            for (int c = 0; c < 64; c++) begin
                for (int p = 0; p < 3; p++) begin
                    logic [63:0] a, r; logic cin, cf, of, cwe, swe;
                    a   = (p == 0) ? (64'hA5C3_1F0E_9B72_6D48 ^ (64'(c) * 64'h9E37_79B9_7F4A_7C15)) :
                          (p == 1) ? (64'h8000_0000_0000_0001 << (c % 7)) : ~(64'd1 << c);
                    cin = (c % 2 == 1) ^ (p == 1);
                    ref_model(3'(op), 8'(c), a, cin, r, cf, of, cwe, swe);
                    run(3'(op), 8'(c), a, cin, r, cf, of, cwe, swe);
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule